// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps recently used logical-to-physical page translations so that a memory unit can turn a logical address into a physical one without walking the page tables. It holds 64 entries, arranged as 16 sets of 4 ways. Each entry carries a valid flag, a tag, a physical page number and a write-protect flag. The tag includes the privilege level of the access, so user and supervisor mappings of the same address are kept apart.

A lookup is started by raising `req_valid` with a logical address, a privilege bit and a write flag. One clock later the response shows either a hit, with the physical address and a protection fault flag, or a miss. After a miss, an external walker supplies the translation through the fill port. The fill is written in one clock, and the requester then retries the lookup, which hits.

Pages are either 4 KB or 8 KB, selected by `page8k`. The page size moves the set index and the tag within the logical address. In 8 KB mode, physical bit 12 is copied from logical bit 12. The `flush` input invalidates every entry. Software is expected to flush around any change of page size.

Top module: `xlat_cache`

## Requirements
- R1: `rsp_valid` is high in the cycle after every cycle in which `req_valid` is high, and low after a cycle without a request. The response fields are registered and belong to that request.
- R2: With `page8k`=0, the set index is logical bits [15:12] and the tag is logical bits [31:16] plus the privilege bit. On a hit, `rsp_paddr` = {stored page number[19:0], logical[11:0]}.
- R3: With `page8k`=1, the set index is logical bits [16:13] and the tag is logical bits [31:17] plus the privilege bit. On a hit, `rsp_paddr` = {stored page number[19:1], logical[12], logical[11:0]}.
- R4: An entry filled with one value of `req_super`/`fill_super` misses for the same address looked up at the other privilege level.
- R5: On a miss, `rsp_miss`=1, `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr`=0.
- R6: A fill completes in one clock. A lookup of the same address in the following cycle hits.
- R7: A fill writes the lowest-numbered invalid way of its set, if the set has one. Filling four different tags into an empty set leaves all four resident.
- R8: In a full set, a fill replaces the way equal to a 2-bit counter. The counter is 0 after reset and advances by one on every lookup, hit or miss. Fills and flushes leave the counter unchanged.
- R9: `flush` invalidates every entry in one clock. If `flush` and `fill_valid` are high together, the fill is dropped.
- R10: A write lookup that hits a write-protected entry gives `rsp_hit`=1 and `rsp_fault`=1. A read lookup of the same entry gives `rsp_fault`=0, and both return the physical address.
- R11: After reset every entry is invalid, the counter is 0 and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page8k | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Logical address to translate |
| req_super | input | 1 | Privilege of the lookup (1 = supervisor) |
| req_write | input | 1 | Lookup is a write access |
| rsp_valid | output | 1 | Response present (one cycle after the strobe) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation missing; a fill is needed |
| rsp_fault | output | 1 | Write to a write-protected page |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_addr | input | 32 | Logical address of the translation being filled |
| fill_super | input | 1 | Privilege bit of the filled translation |
| fill_ppn | input | 20 | Physical page number (physical address bits [31:12]) |
| fill_wp | input | 1 | Write-protect flag of the filled translation |

## Verification
The bench uses the default build: 4 ways and 4 index bits, which gives 16 sets. With only four ways, the two-bit replacement counter wraps after a handful of lookups. The bench can therefore steer which way a full set gives up by counting its own lookups. It can then see the eviction at the ports as exactly one of five addresses in that set missing. Both page sizes are run with the same storage, so the move of bit 16 between tag and index is seen through hits and misses. The copy of bit 12 in 8 KB mode is seen in the physical address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 12;
  localparam int IDX_W  = 4;
  localparam int PPN_W  = VA_W - PG_LSB;
  localparam int TAG_W  = VA_W - PG_LSB - IDX_W + 1;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [VA_W-1:0]  va_t;

  // set index: shifted up by one bit for large pages
  function automatic logic [IDX_W-1:0] set_of(input va_t la, input logic big);
    return big ? la[PG_LSB+1 +: IDX_W] : la[PG_LSB +: IDX_W];
  endfunction

  // tag: privilege plus upper bits; lowest tag bit is an index bit for large pages
  function automatic tag_t tag_of(input va_t la, input logic priv, input logic big);
    tag_t t;
    t = {priv, la[VA_W-1 -: TAG_W-1]};
    if (big) t[0] = 1'b0;
    return t;
  endfunction

  function automatic va_t phys_of(input va_t la, input ppn_t ppn, input logic big);
    va_t pa;
    pa = {ppn, la[PG_LSB-1:0]};
    if (big) pa[PG_LSB] = la[PG_LSB];
    return pa;
  endfunction
endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     access,
  input  logic [WAYS-1:0]          row_valid,
  output logic [$clog2(WAYS)-1:0]  victim,
  output logic [$clog2(WAYS)-1:0]  ctr
);
  localparam int WAY_W = $clog2(WAYS);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctr <= '0;
    else if (access) ctr <= ctr + 1'b1;
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = ctr;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !row_valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [IDX_W-1:0]            lk_set,
  input  tag_t                        lk_tag,
  output logic [WAYS-1:0]             hit_vec,
  output ppn_t                        hit_ppn,
  output logic                        hit_wp,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic [$clog2(WAYS)-1:0]     wr_way,
  input  tag_t                        wr_tag,
  input  ppn_t                        wr_ppn,
  input  logic                        wr_wp,
  output logic [WAYS-1:0]             wr_row_valid,
  output logic [(WAYS<<IDX_W)-1:0]    valid_flat
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SLOTS = WAYS << IDX_W;
  localparam int SLOT_W = IDX_W + WAY_W;

  logic [SLOTS-1:0] vld;
  tag_t             tags [SLOTS];
  ppn_t             ppns [SLOTS];
  logic [SLOTS-1:0] wps;

  wire [SLOT_W-1:0] wr_slot = {wr_set, wr_way};

  always_ff @(posedge clk) begin
    if (!rst_n || flush)  vld <= '0;
    else if (wr_en)       vld[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tags[wr_slot] <= wr_tag;
      ppns[wr_slot] <= wr_ppn;
      wps[wr_slot]  <= wr_wp;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wire [SLOT_W-1:0] lk_slot = {lk_set, WAY_W'(w)};
    wire [SLOT_W-1:0] rw_slot = {wr_set, WAY_W'(w)};
    assign hit_vec[w]      = vld[lk_slot] && (tags[lk_slot] == lk_tag);
    assign wr_row_valid[w] = vld[rw_slot];
  end

  always_comb begin
    hit_ppn = '0;
    hit_wp  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_ppn = hit_ppn | ppns[{lk_set, WAY_W'(w)}];
        hit_wp  = hit_wp  | wps[{lk_set, WAY_W'(w)}];
      end
    end
  end

  assign valid_flat = vld;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page8k,
  input  logic        flush,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_super,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_miss,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  input  logic        fill_valid,
  input  logic [31:0] fill_addr,
  input  logic        fill_super,
  input  logic [19:0] fill_ppn,
  input  logic        fill_wp
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SLOTS  = WAYS << IDX_W;
  localparam int SLOT_W = IDX_W + WAY_W;

  // named internal events for the checker
  logic [WAYS-1:0]  hit_vec;
  logic [WAYS-1:0]  row_valid;
  logic [SLOTS-1:0] valid_flat;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] repl_ctr;
  ppn_t             hit_ppn;
  logic             hit_wp;

  wire [IDX_W-1:0]  lk_set    = set_of(req_addr, page8k);
  wire tag_t        lk_tag    = tag_of(req_addr, req_super, page8k);
  wire [IDX_W-1:0]  fl_set    = set_of(fill_addr, page8k);
  wire tag_t        fl_tag    = tag_of(fill_addr, fill_super, page8k);
  wire              fill_fire = fill_valid && !flush;
  wire [SLOT_W-1:0] fill_slot = {fl_set, fill_way};
  wire              lk_hit    = |hit_vec;

  xlat_store #(.WAYS(WAYS)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .lk_set       (lk_set),
    .lk_tag       (lk_tag),
    .hit_vec      (hit_vec),
    .hit_ppn      (hit_ppn),
    .hit_wp       (hit_wp),
    .wr_en        (fill_fire),
    .wr_set       (fl_set),
    .wr_way       (fill_way),
    .wr_tag       (fl_tag),
    .wr_ppn       (fill_ppn),
    .wr_wp        (fill_wp),
    .wr_row_valid (row_valid),
    .valid_flat   (valid_flat)
  );

  xlat_victim #(.WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .access    (req_valid),
    .row_valid (row_valid),
    .victim    (fill_way),
    .ctr       (repl_ctr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_hit;
      rsp_miss  <= req_valid && !lk_hit;
      rsp_fault <= req_valid && lk_hit && hit_wp && req_write;
      rsp_paddr <= (req_valid && lk_hit) ? phys_of(req_addr, hit_ppn, page8k) : '0;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int WAYS  = 4,
  parameter int SLOTS = 64,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page8k,
  input logic              flush,
  input logic              req_valid,
  input logic [31:0]       req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_fault,
  input logic [31:0]       rsp_paddr,
  input logic              fill_fire,
  input logic [SLOT_W-1:0] fill_slot,
  input logic [WAYS-1:0]   row_valid,
  input logic [SLOTS-1:0]  valid_flat,
  input logic [$clog2(WAYS)-1:0] repl_ctr
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_bit12_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && $past(page8k) |-> rsp_paddr[12] == $past(req_addr[12]));
  p_miss_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> !rsp_hit && !rsp_fault && rsp_paddr == '0);
  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && !flush |=> valid_flat[$past(fill_slot)]);
  p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && !(&row_valid) |-> !valid_flat[fill_slot]);
  p_ctr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> repl_ctr == $past(repl_ctr) + 1'b1);
  p_ctr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(repl_ctr));
  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_flat == '0);
  p_fault_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit && $past(req_write));
endmodule

bind xlat_cache xlat_cache_chk #(.WAYS(WAYS), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .page8k     (page8k),
  .flush      (flush),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_miss   (rsp_miss),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .fill_fire  (fill_fire),
  .fill_slot  (fill_slot),
  .row_valid  (row_valid),
  .valid_flat (valid_flat),
  .repl_ctr   (repl_ctr)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n, page8k, flush;
  logic        req_valid, req_super, req_write;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_valid, fill_super, fill_wp;
  logic [31:0] fill_addr;
  logic [19:0] fill_ppn;

  int checks = 0;
  int errors = 0;
  int lkp_count = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_cache u_dut (.*);

  typedef struct packed {
    logic [1:0]  op;      // 0 lookup, 1 fill
    logic        sup;
    logic        wr;
    logic [31:0] la;
    logic [19:0] ppn;
    logic        wp;
    logic        e_hit;
    logic        e_flt;
    logic [31:0] e_pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 32'h0000_3abc, 20'h0,     1'b0, 1'b0, 1'b0, 32'h0},          // R5 cold miss
    '{2'd1, 1'b0, 1'b0, 32'h0000_3abc, 20'h12345, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd0, 1'b0, 1'b0, 32'h0000_3abc, 20'h0,     1'b0, 1'b1, 1'b0, 32'h1234_5abc},  // R6
    '{2'd0, 1'b1, 1'b0, 32'h0000_3abc, 20'h0,     1'b0, 1'b0, 1'b0, 32'h0},          // R4
    '{2'd0, 1'b0, 1'b0, 32'h0001_3abc, 20'h0,     1'b0, 1'b0, 1'b0, 32'h0},          // R2 bit16 in tag
    '{2'd1, 1'b0, 1'b0, 32'h0001_3000, 20'h00abc, 1'b1, 1'b0, 1'b0, 32'h0},
    '{2'd0, 1'b0, 1'b0, 32'h0001_3010, 20'h0,     1'b0, 1'b1, 1'b0, 32'h00ab_c010},  // R10 read
    '{2'd0, 1'b0, 1'b1, 32'h0001_3010, 20'h0,     1'b0, 1'b1, 1'b1, 32'h00ab_c010},  // R10 write
    '{2'd0, 1'b0, 1'b1, 32'h0000_3fff, 20'h0,     1'b0, 1'b1, 1'b0, 32'h1234_5fff},  // R2
    '{2'd0, 1'b0, 1'b0, 32'h0000_4abc, 20'h0,     1'b0, 1'b0, 1'b0, 32'h0}           // R5
  };

  function automatic string vtag(int i);
    case (i)
      0, 9:    return "R5";
      2:       return "R6";
      3:       return "R4";
      6, 7:    return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [31:0] la, logic s, logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = la; req_super = s; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    lkp_count++;
  endtask

  task automatic expect_lkp(string req, logic [31:0] la, logic s, logic w,
                            logic e_hit, logic [31:0] e_pa, logic e_flt);
    lookup(la, s, w);
    check("R1", {31'b0, rsp_valid}, 32'd1);
    check(req, {29'b0, rsp_hit, rsp_miss, rsp_fault}, {29'b0, e_hit, !e_hit, e_flt});
    check(req, rsp_paddr, e_pa);
  endtask

  task automatic fill(logic [31:0] la, logic s, logic [19:0] ppn, logic wp, logic fl);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = la; fill_super = s; fill_ppn = ppn; fill_wp = wp;
    flush = fl;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; page8k = 1'b0; flush = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_super = 1'b0; req_write = 1'b0;
    fill_valid = 1'b0; fill_addr = '0; fill_super = 1'b0; fill_ppn = '0; fill_wp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: outputs quiet after reset
    check("R11", {27'b0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, 1'b0}, 32'd0);
    check("R11", rsp_paddr, 32'd0);

    // vector walk in 4 KB mode
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd1)
        fill(VECS[i].la, VECS[i].sup, VECS[i].ppn, VECS[i].wp, 1'b0);
      else
        expect_lkp(vtag(i), VECS[i].la, VECS[i].sup, VECS[i].wr,
                   VECS[i].e_hit, VECS[i].e_pa, VECS[i].e_flt);
    end
    @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'd0);

    // R9: flush clears everything
    do_flush();
    expect_lkp("R9", 32'h0000_3abc, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    // R9: flush wins over a simultaneous fill
    fill(32'h0000_8000, 1'b0, 20'h77777, 1'b0, 1'b1);
    expect_lkp("R9", 32'h0000_8000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);

    // R7: four tags into empty set 5 all stay resident
    for (int k = 0; k < 4; k++)
      fill(32'h0000_5000 | (k << 16), 1'b0, 20'h10000 + 20'(k), 1'b0, 1'b0);
    for (int k = 0; k < 4; k++)
      expect_lkp("R7", 32'h0000_5000 | (k << 16), 1'b0, 1'b0, 1'b1,
                 {20'h10000 + 20'(k), 12'h000}, 1'b0);
    expect_lkp("R8", 32'h0000_9000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);

    // R8: full set replaces the way named by the lookup counter
    begin
      int v;
      v = lkp_count % 4;   // way k holds tag k (lowest-invalid order)
      fill(32'h0004_5000, 1'b0, 20'h44444, 1'b0, 1'b0);
      expect_lkp("R8", 32'h0004_5000, 1'b0, 1'b0, 1'b1, 32'h4444_4000, 1'b0);
      for (int k = 0; k < 4; k++)
        expect_lkp("R8", 32'h0000_5000 | (k << 16), 1'b0, 1'b0, (k != v),
                   (k != v) ? {20'h10000 + 20'(k), 12'h000} : 32'h0, 1'b0);
    end

    // R3: 8 KB pages
    do_flush();
    page8k = 1'b1;
    fill(32'h0002_6000, 1'b0, 20'h54321, 1'b0, 1'b0);
    expect_lkp("R3", 32'h0002_6000, 1'b0, 1'b0, 1'b1, 32'h5432_0000, 1'b0);
    expect_lkp("R3", 32'h0002_7123, 1'b0, 1'b0, 1'b1, 32'h5432_1123, 1'b0);
    expect_lkp("R3", 32'h0003_6000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    fill(32'h0003_6000, 1'b0, 20'h11110, 1'b0, 1'b0);
    expect_lkp("R3", 32'h0003_7abc, 1'b0, 1'b0, 1'b1, 32'h1111_1abc, 1'b0);
    expect_lkp("R3", 32'h0002_6004, 1'b0, 1'b0, 1'b1, 32'h5432_0004, 1'b0);
    expect_lkp("R4", 32'h0002_6004, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule